// File: doc/BRIEF.md
# Filtered-Edge Interrupt Flag Controller

This block sits between sixteen external interrupt lines and a small microcontroller core. Each line is synchronized and watched for a falling edge that is clean on both sides. The line must have been high for two sampled cycles, and it must then be low for two sampled cycles. Only such an edge sets that line's sticky flag. A per-line mask and a global interrupt enable from the core decide which flags become a request. When several requests are present, the lowest-numbered line is presented, together with its index.

Software sees the flags and masks through four byte-wide registers in a small I/O window. Each register covers four lines. The flags sit in the upper nibble and are cleared by writing 1. The masks sit in the lower nibble and are plain read/write. A mode input chooses what the window does. In one mode the four addresses reach these registers. In the other mode they are decoded into four one-hot select strobes for external logic, and the registers are left alone. The core clears a flag in hardware by acknowledging that line's vector. While the core is in deep sleep, the lowest four lines are sensed by level, so that a held-low line can wake it.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A falling edge on line i sets flag i when the synchronized line was high for at least 2 cycles before the edge and is low for at least 2 cycles after it.
- R2: A low pulse that lasts fewer than 2 cycles does not set the flag.
- R3: A falling edge that follows fewer than 2 high cycles does not set the flag.
- R4: When ack_i is 1 for one cycle, the flag selected by ack_idx_i is cleared.
- R5: Writing a register clears each flag whose write-data bit is 1 and leaves each flag whose bit is 0 unchanged.
- R6: irq_req_o is 1 only when gie_i is 1 and at least one line has both its flag and its mask at 1.
- R7: Register k (k = 0..3, selected by io_addr_i) reads flags of lines 4k+3..4k in bits 7..4 and masks of lines 4k+3..4k in bits 3..0, with the higher line in the higher bit. Mask bits are written directly from bits 3..0.
- R8: After reset all flags and masks read 0, irq_req_o is 0 and ext_sel_o is 0.
- R9: With map_regs_i = 0, an access with io_sel_i = 1 drives ext_sel_o one-hot at bit io_addr_i, reads return 0 and the registers do not change. With map_regs_i = 1, ext_sel_o stays 0.
- R10: Among enabled pending lines the lowest-numbered one is reported on irq_idx_o.
- R11: While deep_sleep_i is 1, lines 0..3 set their flag continuously while held low. Lines 4..15 still need a qualified edge.
- R12: When a flag set and a write-1 clear of the same flag occur in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line_i | input | 16 | External interrupt lines, idle high |
| gie_i | input | 1 | Global interrupt enable from the core |
| deep_sleep_i | input | 1 | Core is in a deep sleep mode |
| map_regs_i | input | 1 | 1: window reaches registers; 0: window drives select strobes |
| io_sel_i | input | 1 | Access to the four-address window |
| io_addr_i | input | 2 | Register index inside the window |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, combinational |
| ext_sel_o | output | 4 | One-hot external select strobes |
| ack_i | input | 1 | Core acknowledges an interrupt vector |
| ack_idx_i | input | 4 | Line whose vector is acknowledged |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_idx_o | output | 4 | Index of the reported line |

## Verification
The edge filter is driven with pulse shapes that vary the high time before the edge and the low time after it. These include the exact two-and-two case, a one-cycle glitch and a one-cycle high pre-phase, so that a filter that is too loose or too strict gives a different flag. Requests are tried with each gating input removed in turn and with two lines pending at once, which separates correct priority from plain OR logic. A falling edge is timed to land in the same cycle as a write-1 clear, which shows which of the two wins. Held-low lines are used in and out of deep sleep, on a wake line and on an ordinary line, to separate level sensing from edge sensing.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

   // Lines served by one byte register: flags in the upper half, masks in the lower.
   localparam int unsigned LINES_PER_REG = 4;

   typedef enum logic {
      WIN_STROBES = 1'b0,
      WIN_REGS    = 1'b1
   } win_mode_e;

   // Bit set on every line index below wake_cnt
   function automatic logic [63:0] low_lines_mask(input int unsigned wake_cnt);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < 64; i++) begin
         if (i < int'(wake_cnt)) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/irq_edge_qual.sv
module irq_edge_qual #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD        = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic fall_o,
   output logic low_o
);
   localparam int unsigned HIST_W = 2 * HOLD;
   localparam logic [HIST_W-1:0] FALL_PAT = {{HOLD{1'b1}}, {HOLD{1'b0}}};

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_edge_qual: SYNC_STAGES must be at least 2");
   end
   if (HOLD < 1) begin : g_bad_hold
      $error("irq_edge_qual: HOLD must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [HIST_W-1:0]      hist_q;
   logic                   level;

   assign level = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         hist_q <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
         hist_q <= {hist_q[HIST_W-2:0], level};
      end
   end

   // Oldest samples high, newest samples low: one clean falling edge
   assign fall_o = (hist_q == FALL_PAT);
   assign low_o  = ~level;

endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file #(
   parameter int unsigned N      = 16,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned L     = DATA_W / 2,
   localparam int unsigned REGS  = N / L,
   localparam int unsigned AW    = $clog2(REGS),
   localparam int unsigned IW    = $clog2(N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [AW-1:0]     addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [N-1:0]      set_i,
   input  logic              ack_i,
   input  logic [IW-1:0]     ack_idx_i,
   output logic [N-1:0]      flags_o,
   output logic [N-1:0]      masks_o,
   output logic [DATA_W-1:0] rdata_o
);
   logic [N-1:0] flags_q, masks_q;
   logic [N-1:0] clr_vec, ack_vec, mask_nxt;

   always_comb begin
      clr_vec  = '0;
      mask_nxt = masks_q;
      if (we_i) begin
         clr_vec[addr_i*L +: L]  = wdata_i[DATA_W-1:L];
         mask_nxt[addr_i*L +: L] = wdata_i[L-1:0];
      end
      ack_vec = ack_i ? (N'(1) << ack_idx_i) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         masks_q <= '0;
      end else begin
         // a new event outranks any clear in the same cycle
         flags_q <= (flags_q & ~(clr_vec | ack_vec)) | set_i;
         masks_q <= mask_nxt;
      end
   end

   assign rdata_o = {flags_q[addr_i*L +: L], masks_q[addr_i*L +: L]};
   assign flags_o = flags_q;
   assign masks_o = masks_q;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned N  = 16,
   localparam int unsigned IW = $clog2(N)
) (
   input  logic [N-1:0]  pend_i,
   output logic          req_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend_i[i]) idx_o = IW'(i);
      end
   end
   assign req_o = |pend_i;

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD        = 2,
   parameter int unsigned WAKE_LINES  = 4,
   localparam int unsigned REGS       = NUM_LINES / (DATA_W / 2),
   localparam int unsigned AW         = $clog2(REGS),
   localparam int unsigned IW         = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_line_i,
   input  logic                 gie_i,
   input  logic                 deep_sleep_i,
   input  logic                 map_regs_i,
   input  logic                 io_sel_i,
   input  logic [AW-1:0]        io_addr_i,
   input  logic                 io_wr_i,
   input  logic                 io_rd_i,
   input  logic [DATA_W-1:0]    io_wdata_i,
   output logic [DATA_W-1:0]    io_rdata_o,
   output logic [REGS-1:0]      ext_sel_o,
   input  logic                 ack_i,
   input  logic [IW-1:0]        ack_idx_i,
   output logic                 irq_req_o,
   output logic [IW-1:0]        irq_idx_o
);
   localparam logic [63:0]          WAKE_ALL  = low_lines_mask(WAKE_LINES);
   localparam logic [NUM_LINES-1:0] WAKE_MASK = WAKE_ALL[NUM_LINES-1:0];

   if (DATA_W != 2 * LINES_PER_REG) begin : g_bad_width
      $error("irq_flag_ctrl: DATA_W must hold one nibble of flags and one of masks");
   end
   if (NUM_LINES % LINES_PER_REG != 0 || REGS < 2) begin : g_bad_lines
      $error("irq_flag_ctrl: NUM_LINES must be a multiple of the register width and span two registers");
   end
   if (WAKE_LINES > NUM_LINES || NUM_LINES > 64) begin : g_bad_wake
      $error("irq_flag_ctrl: WAKE_LINES or NUM_LINES out of range");
   end

   win_mode_e             win_mode;
   logic [NUM_LINES-1:0]  fall_vec, low_vec, set_vec;
   logic [NUM_LINES-1:0]  flags_q, masks_q;
   logic [DATA_W-1:0]     reg_rdata;
   logic                  reg_we;

   assign win_mode = win_mode_e'(map_regs_i);

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      irq_edge_qual #(
         .SYNC_STAGES(SYNC_STAGES),
         .HOLD       (HOLD)
      ) u_qual (
         .clk   (clk),
         .rst_n (rst_n),
         .line_i(irq_line_i[g]),
         .fall_o(fall_vec[g]),
         .low_o (low_vec[g])
      );
   end

   // level sensing only on wake lines and only in deep sleep
   assign set_vec = fall_vec | (low_vec & WAKE_MASK & {NUM_LINES{deep_sleep_i}});

   assign reg_we = (win_mode == WIN_REGS) && io_sel_i && io_wr_i;

   irq_reg_file #(
      .N     (NUM_LINES),
      .DATA_W(DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (reg_we),
      .addr_i   (io_addr_i),
      .wdata_i  (io_wdata_i),
      .set_i    (set_vec),
      .ack_i    (ack_i),
      .ack_idx_i(ack_idx_i),
      .flags_o  (flags_q),
      .masks_o  (masks_q),
      .rdata_o  (reg_rdata)
   );

   assign io_rdata_o = ((win_mode == WIN_REGS) && io_sel_i && io_rd_i) ? reg_rdata : '0;
   assign ext_sel_o  = ((win_mode == WIN_STROBES) && io_sel_i) ? (REGS'(1) << io_addr_i) : '0;

   irq_prio_enc #(
      .N(NUM_LINES)
   ) u_prio (
      .pend_i(flags_q & masks_q & {NUM_LINES{gie_i}}),
      .req_o (irq_req_o),
      .idx_o (irq_idx_o)
   );

endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
   parameter int unsigned N    = 16,
   parameter int unsigned REGS = 4,
   localparam int unsigned IW  = $clog2(N)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            gie_i,
   input logic            map_regs_i,
   input logic            ack_i,
   input logic            reg_we,
   input logic            irq_req_o,
   input logic [IW-1:0]   irq_idx_o,
   input logic [REGS-1:0] ext_sel_o,
   input logic [N-1:0]    flags_q,
   input logic [N-1:0]    masks_q,
   input logic [N-1:0]    set_vec
);
   // R6: a request needs enable, flag and mask of the reported line
   a_r6_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> (gie_i && flags_q[irq_idx_o] && masks_q[irq_idx_o]));

   // R10: no enabled pending line below the reported one
   a_r10_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> (((flags_q & masks_q) & ((N'(1) << irq_idx_o) - N'(1))) == '0));

   // R9: strobes are one-hot at most
   a_r9_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ext_sel_o));

   // R9: register mode never drives strobes
   a_r9_no_sel_in_reg_mode: assert property (@(posedge clk) disable iff (!rst_n)
      map_regs_i |-> (ext_sel_o == '0));

   // R4 and R5: a flag only drops after a write or an acknowledge
   a_r5_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(flags_q) & ~flags_q)) |-> $past(reg_we || ack_i));

   // R1: a flag only rises after a set from the line logic
   a_r1_set_source: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flags_q & ~$past(flags_q))) |-> $past(|set_vec));

   // R12: a pending set is never lost
   a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
   .N   (NUM_LINES),
   .REGS(REGS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .gie_i     (gie_i),
   .map_regs_i(map_regs_i),
   .ack_i     (ack_i),
   .reg_we    (reg_we),
   .irq_req_o (irq_req_o),
   .irq_idx_o (irq_idx_o),
   .ext_sel_o (ext_sel_o),
   .flags_q   (flags_q),
   .masks_q   (masks_q),
   .set_vec   (set_vec)
);

// File: tb/test_irq_flag_ctrl.sv
module test_irq_flag_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_line = '1;
   logic        gie = 1'b0, deep_sleep = 1'b0, map_regs = 1'b1;
   logic        io_sel = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
   logic [1:0]  io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [3:0]  ext_sel;
   logic        ack = 1'b0;
   logic [3:0]  ack_idx = '0;
   logic        irq_req;
   logic [3:0]  irq_idx;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   irq_flag_ctrl i_irq_flag_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_line_i(irq_line), .gie_i(gie),
      .deep_sleep_i(deep_sleep), .map_regs_i(map_regs), .io_sel_i(io_sel),
      .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd),
      .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .ext_sel_o(ext_sel),
      .ack_i(ack), .ack_idx_i(ack_idx), .irq_req_o(irq_req), .irq_idx_o(irq_idx)
   );

   // fields: line index, high cycles before, low cycles after, expected flag
   localparam logic [15:0] VEC [0:5] = '{
      16'h3441, 16'h3410, 16'h9221, 16'hF431, 16'h0140, 16'hC310
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      io_sel = 1'b1; io_wr = 1'b1; io_addr = a; io_wdata = d;
      @(negedge clk);
      io_sel = 1'b0; io_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      io_sel = 1'b1; io_rd = 1'b1; io_addr = a;
      #1 d = io_rdata;
      io_sel = 1'b0; io_rd = 1'b0;
   endtask

   initial begin : watchdog
      #(200000 * 4);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] d;
      cyc(3);
      rst_n = 1'b1;
      cyc(2);

      // R8 reset state
      for (int k = 0; k < 4; k++) begin
         rd(2'(k), d);
         check("R8 reset reg", {24'd0, d}, 32'h0);
      end
      check("R8 reset req", {31'd0, irq_req}, 32'd0);
      check("R8 reset sel", {28'd0, ext_sel}, 32'd0);

      // table of edge shapes: R1 R2 R3
      for (int v = 0; v < 6; v++) begin
         automatic int li = int'(VEC[v][15:12]);
         automatic int hb = int'(VEC[v][11:8]);
         automatic int lc = int'(VEC[v][7:4]);
         automatic logic ex = VEC[v][0];
         irq_line[li] = 1'b0;
         cyc(6);
         wr(2'(li / 4), 8'hF0);
         irq_line[li] = 1'b1;
         cyc(hb);
         irq_line[li] = 1'b0;
         cyc(lc);
         irq_line[li] = 1'b1;
         cyc(8);
         rd(2'(li / 4), d);
         check(ex ? "R1 qualified edge" : "R2 R3 rejected edge",
               {31'd0, d[4 + li % 4]}, {31'd0, ex});
         wr(2'(li / 4), 8'hF0);
         cyc(4);
      end

      // R7 mask layout
      wr(2'd2, 8'h0A);
      rd(2'd2, d);
      check("R7 mask nibble", {24'd0, d}, 32'h0A);

      // R7 flag position: line 9 -> reg 2 bit 5
      irq_line[9] = 1'b0; cyc(8); irq_line[9] = 1'b1; cyc(6);
      rd(2'd2, d);
      check("R7 flag bit position", {24'd0, d}, 32'h2A);

      // R5 write 0 keeps flag, masks rewritten
      wr(2'd2, 8'h0A);
      rd(2'd2, d);
      check("R5 write 0 keeps flag", {24'd0, d}, 32'h2A);

      // R6 gating
      check("R6 gie off", {31'd0, irq_req}, 32'd0);
      gie = 1'b1; cyc(1);
      check("R6 all set req", {31'd0, irq_req}, 32'd1);
      check("R10 index single", {28'd0, irq_idx}, 32'd9);
      wr(2'd2, 8'h08);
      check("R6 mask off", {31'd0, irq_req}, 32'd0);
      wr(2'd2, 8'h0A);

      // R10 priority: line 5 (reg1 mask bit1) also pending
      wr(2'd1, 8'h02);
      irq_line[5] = 1'b0; cyc(8); irq_line[5] = 1'b1; cyc(6);
      check("R10 lowest wins", {28'd0, irq_idx}, 32'd5);

      // R4 acknowledge clears line 5
      @(negedge clk); ack = 1'b1; ack_idx = 4'd5;
      @(negedge clk); ack = 1'b0;
      check("R4 ack cleared", {28'd0, irq_idx}, 32'd9);
      rd(2'd1, d);
      check("R4 ack flag", {24'd0, d}, 32'h02);

      // R5 write 1 clears line 9
      wr(2'd2, 8'h2A);
      rd(2'd2, d);
      check("R5 write 1 clears", {24'd0, d}, 32'h0A);
      check("R6 no flag no req", {31'd0, irq_req}, 32'd0);

      // R9 strobe mode
      map_regs = 1'b0;
      @(negedge clk); io_sel = 1'b1; io_addr = 2'd2; io_wr = 1'b1; io_rd = 1'b1; io_wdata = 8'hFF;
      #1;
      check("R9 strobe onehot", {28'd0, ext_sel}, 32'h4);
      check("R9 strobe read zero", {24'd0, io_rdata}, 32'h0);
      @(negedge clk); io_sel = 1'b0; io_wr = 1'b0; io_rd = 1'b0;
      map_regs = 1'b1;
      rd(2'd2, d);
      check("R9 regs untouched", {24'd0, d}, 32'h0A);
      @(negedge clk); io_sel = 1'b1; io_addr = 2'd1; #1;
      check("R9 no strobe in reg mode", {28'd0, ext_sel}, 32'h0);
      io_sel = 1'b0;

      // R12 set and clear collide on line 7 (reg1 bit7)
      irq_line[7] = 1'b0; cyc(8); irq_line[7] = 1'b1; cyc(6);
      rd(2'd1, d);
      check("R12 preset flag", {31'd0, d[7]}, 32'd1);
      @(negedge clk); irq_line[7] = 1'b0;
      cyc(4);
      io_sel = 1'b1; io_wr = 1'b1; io_addr = 2'd1; io_wdata = 8'h82;
      @(negedge clk); io_sel = 1'b0; io_wr = 1'b0;
      rd(2'd1, d);
      check("R12 set beats clear", {31'd0, d[7]}, 32'd1);
      irq_line[7] = 1'b1; cyc(6);
      wr(2'd1, 8'h82);
      rd(2'd1, d);
      check("R5 clear after collision", {31'd0, d[7]}, 32'd0);

      // R11 held low outside sleep: edge only
      irq_line[2] = 1'b0; cyc(8);
      wr(2'd0, 8'h40); cyc(3);
      rd(2'd0, d);
      check("R11 awake no level", {31'd0, d[6]}, 32'd0);
      irq_line[2] = 1'b1; cyc(6);
      // in deep sleep
      deep_sleep = 1'b1;
      irq_line[2] = 1'b0; irq_line[6] = 1'b0; cyc(8);
      wr(2'd0, 8'h40); wr(2'd1, 8'h42); cyc(3);
      rd(2'd0, d);
      check("R11 wake line level", {31'd0, d[6]}, 32'd1);
      rd(2'd1, d);
      check("R11 other line edge only", {31'd0, d[6]}, 32'd0);
      deep_sleep = 1'b0;
      irq_line = '1;
      cyc(4);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule